// File: doc/BRIEF.md
# Bridge Upstream Request Gating Unit

This block sits on the secondary side of a virtual PCI-to-PCI Express bridge port. It holds the port's 16-bit command register, written through a simple configuration write strobe. It also filters the stream of upstream request descriptors according to the bus-mastering bit in that register. Each descriptor carries a kind, an address, byte enables, a tag and a length. It passes through a single register stage with a valid/ready handshake.

While bus mastering is off, requests are not dropped. Write-class requests leave with address zero and every byte enable cleared. Reads leave with address zero, and each one causes the block to return an Unsupported Request completion to the secondary side, in request order, with the original tag. Completions arriving from the primary side always pass straight through to the secondary side and take precedence over these locally generated completions.

The register's enables also gate the claiming of downstream memory and I/O decodes. The parity enable gates a sticky parity-error status bit. The error-message enable is formed as the OR of the register's write-once enable and a device-control enable input.

Top module: `usreq_gate`

## Requirements
- R1: After reset the command register reads 0, no descriptor is presented upstream, no completion is presented to the secondary side, and the parity status bit is 0.
- R2: Command bits 0 (I/O enable), 1 (memory enable), 2 (bus-master enable) and 6 (parity enable) are read/write. Bits 3, 4, 5, 7 and 9 to 15 always read 0, whatever is written.
- R3: Bit 8 (error-message enable) takes the value of the first configuration write after reset. Later writes leave it unchanged.
- R4: With bit 2 set when a descriptor is accepted, it is presented upstream unchanged, with the invalidated flag at 0.
- R5: With bit 2 clear when a write-class descriptor is accepted, it is presented with address 0, byte enables 0, its kind, tag and length unchanged, and the invalidated flag at 1. Kind encodings: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 message-signalled interrupt write. Every kind other than 0 and 2 is write-class.
- R6: With bit 2 clear when a read (kind 0 or 2) is accepted, it is presented with address 0, byte enables, tag and length unchanged, and the invalidated flag at 1. Exactly one completion with status 1 (Unsupported Request) and that tag is returned to the secondary side, in the order the reads were accepted.
- R7: The bus-master enable value used for a descriptor is the one held in the cycle the descriptor is accepted. A request accepted in the same cycle as a configuration write still sees the old value.
- R8: A presented descriptor holds stable while its ready is low. The input is ready only when the stage is empty or draining and the local completion queue has room.
- R9: A primary completion is presented to the secondary side unchanged (tag and status; status 0 means successful), whatever the command register holds. It takes precedence over local completions, and the primary ready equals the secondary ready.
- R10: A downstream memory hit is claimed only while bit 1 is set. A downstream I/O hit is claimed only while bit 0 is set.
- R11: The parity status bit becomes 1 after a parity event only while bit 6 is set. A clear pulse resets it, and a set in the same cycle wins.
- R12: The error-message output is 1 when bit 8 is set or the device-control enable input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Command register write strobe |
| cfg_wdata | input | 16 | Command register write data |
| cfg_rdata | output | 16 | Command register value |
| devctl_err_en | input | 1 | Device-control error reporting enable |
| serr_msg_en | output | 1 | Combined error-message enable |
| par_err_evt | input | 1 | Master data parity error event |
| sts_clr | input | 1 | Clear pulse for parity status |
| mdpe_sts | output | 1 | Sticky parity error status |
| dn_mem_hit | input | 1 | Downstream memory range hit |
| dn_io_hit | input | 1 | Downstream I/O range hit |
| dn_mem_claim | output | 1 | Memory hit claimed |
| dn_io_claim | output | 1 | I/O hit claimed |
| up_in_valid | input | 1 | Upstream descriptor valid |
| up_in_ready | output | 1 | Upstream descriptor accepted |
| up_in_kind | input | 3 | Request kind |
| up_in_addr | input | AW | Request address |
| up_in_be | input | BEW | Byte enables |
| up_in_tag | input | TW | Request tag |
| up_in_len | input | LW | Request length |
| up_out_valid | output | 1 | Forwarded descriptor valid |
| up_out_ready | input | 1 | Forwarded descriptor taken |
| up_out_kind | output | 3 | Forwarded kind |
| up_out_addr | output | AW | Forwarded address |
| up_out_be | output | BEW | Forwarded byte enables |
| up_out_tag | output | TW | Forwarded tag |
| up_out_len | output | LW | Forwarded length |
| up_out_inv | output | 1 | Descriptor was invalidated |
| pri_cpl_valid | input | 1 | Primary completion valid |
| pri_cpl_ready | output | 1 | Primary completion taken |
| pri_cpl_tag | input | TW | Primary completion tag |
| pri_cpl_status | input | 2 | Primary completion status |
| sec_cpl_valid | output | 1 | Secondary completion valid |
| sec_cpl_ready | input | 1 | Secondary completion taken |
| sec_cpl_tag | output | TW | Secondary completion tag |
| sec_cpl_status | output | 2 | Secondary completion status |

## Verification
The hardest situation to reach is a full local completion queue: several invalidated reads must be accepted while primary completions keep the secondary port busy or the secondary ready is held low. The stimulus gets there with phases of dense, read-heavy traffic while bus mastering is off, with frequent primary completions and a rarely asserted secondary ready. A directed sequence also places a request in the same cycle as the write that turns bus mastering on, which covers the acceptance-time sampling rule.

// File: rtl/usreq_pkg.sv
package usreq_pkg;
   typedef enum logic [2:0] {
      K_MRD  = 3'd0,
      K_MWR  = 3'd1,
      K_IORD = 3'd2,
      K_IOWR = 3'd3,
      K_MSI  = 3'd4
   } req_kind_e;

   localparam int CMD_W   = 16;
   localparam int CB_IO   = 0;
   localparam int CB_MEM  = 1;
   localparam int CB_BME  = 2;
   localparam int CB_PERR = 6;
   localparam int CB_SERR = 8;

   localparam logic [CMD_W-1:0] RW_MASK =
      CMD_W'((1 << CB_IO) | (1 << CB_MEM) | (1 << CB_BME) | (1 << CB_PERR));

   localparam logic [1:0] CPL_SC = 2'd0;
   localparam logic [1:0] CPL_UR = 2'd1;

   function automatic logic kind_is_read(input logic [2:0] k);
      return (k == K_MRD) || (k == K_IORD);
   endfunction
endpackage

// File: rtl/usreq_cmd_reg.sv
module usreq_cmd_reg
   import usreq_pkg::*;
#(
   parameter bit SERR_ONCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CMD_W-1:0] cfg_wdata,
   input  logic             par_err_evt,
   input  logic             sts_clr,
   input  logic             devctl_err_en,
   output logic [CMD_W-1:0] cmd,
   output logic             mdpe_sts,
   output logic             serr_msg_en
);
   logic [CMD_W-1:0] rw_q;
   logic             serr_q;
   logic             mdpe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rw_q <= '0;
      else if (cfg_wr) rw_q <= cfg_wdata & RW_MASK;
   end

   generate
      if (SERR_ONCE) begin : g_serr_once
         logic lock_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               serr_q <= 1'b0;
               lock_q <= 1'b0;
            end else if (cfg_wr) begin
               lock_q <= 1'b1;
               if (!lock_q) serr_q <= cfg_wdata[CB_SERR];
            end
         end
      end else begin : g_serr_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      serr_q <= 1'b0;
            else if (cfg_wr) serr_q <= cfg_wdata[CB_SERR];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mdpe_q <= 1'b0;
      else if (par_err_evt && rw_q[CB_PERR]) mdpe_q <= 1'b1;
      else if (sts_clr)                    mdpe_q <= 1'b0;
   end

   always_comb begin
      cmd          = rw_q;
      cmd[CB_SERR] = serr_q;
   end

   assign mdpe_sts    = mdpe_q;
   assign serr_msg_en = serr_q | devctl_err_en;
endmodule

// File: rtl/usreq_stage.sv
module usreq_stage
   import usreq_pkg::*;
#(
   parameter int AW  = 32,
   parameter int BEW = 4,
   parameter int TW  = 8,
   parameter int LW  = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bme,
   input  logic           q_full,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [2:0]     in_kind,
   input  logic [AW-1:0]  in_addr,
   input  logic [BEW-1:0] in_be,
   input  logic [TW-1:0]  in_tag,
   input  logic [LW-1:0]  in_len,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [2:0]     out_kind,
   output logic [AW-1:0]  out_addr,
   output logic [BEW-1:0] out_be,
   output logic [TW-1:0]  out_tag,
   output logic [LW-1:0]  out_len,
   output logic           out_inv,
   output logic           push,
   output logic [TW-1:0]  push_tag
);
   logic           ov_q, inv_q;
   logic [2:0]     kind_q;
   logic [AW-1:0]  addr_q;
   logic [BEW-1:0] be_q;
   logic [TW-1:0]  tag_q;
   logic [LW-1:0]  len_q;
   logic           take, rd, kill;

   assign in_ready = (!ov_q || out_ready) && !q_full;
   assign take     = in_valid && in_ready;
   assign rd       = kind_is_read(in_kind);
   assign kill     = !bme;
   assign push     = take && kill && rd;
   assign push_tag = in_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ov_q <= 1'b0;
      else if (take)      ov_q <= 1'b1;
      else if (out_ready) ov_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= '0;
         addr_q <= '0;
         be_q   <= '0;
         tag_q  <= '0;
         len_q  <= '0;
         inv_q  <= 1'b0;
      end else if (take) begin
         kind_q <= in_kind;
         addr_q <= kill ? '0 : in_addr;
         be_q   <= (kill && !rd) ? '0 : in_be;
         tag_q  <= in_tag;
         len_q  <= in_len;
         inv_q  <= kill;
      end
   end

   assign out_valid = ov_q;
   assign out_kind  = kind_q;
   assign out_addr  = addr_q;
   assign out_be    = be_q;
   assign out_tag   = tag_q;
   assign out_len   = len_q;
   assign out_inv   = inv_q;
endmodule

// File: rtl/usreq_urq.sv
module usreq_urq #(
   parameter int TW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [TW-1:0] push_tag,
   input  logic          pop,
   output logic          empty,
   output logic          full,
   output logic [TW-1:0] head_tag
);
   generate
      if (DEPTH == 1) begin : g_single
         logic          v_q;
         logic [TW-1:0] t_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               t_q <= '0;
            end else if (push) begin
               v_q <= 1'b1;
               t_q <= push_tag;
            end else if (pop) begin
               v_q <= 1'b0;
            end
         end
         assign empty    = !v_q;
         assign full     = v_q;
         assign head_tag = t_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [TW-1:0] mem [DEPTH];
         logic [PW-1:0] wp_q, rp_q;
         logic [CW-1:0] cnt_q;

         function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         always_ff @(posedge clk) begin
            if (push) mem[wp_q] <= push_tag;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wp_q <= bump(wp_q);
               if (pop)  rp_q <= bump(rp_q);
               if (push && !pop)      cnt_q <= cnt_q + CW'(1);
               else if (pop && !push) cnt_q <= cnt_q - CW'(1);
            end
         end

         assign empty    = (cnt_q == '0);
         assign full     = (cnt_q == CW'(DEPTH));
         assign head_tag = mem[rp_q];
      end
   endgenerate
endmodule

// File: rtl/usreq_cpl_mux.sv
module usreq_cpl_mux
   import usreq_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          pri_valid,
   output logic          pri_ready,
   input  logic [TW-1:0] pri_tag,
   input  logic [1:0]    pri_status,
   input  logic          q_empty,
   input  logic [TW-1:0] q_head,
   output logic          q_pop,
   output logic          sec_valid,
   input  logic          sec_ready,
   output logic [TW-1:0] sec_tag,
   output logic [1:0]    sec_status
);
   always_comb begin
      pri_ready = sec_ready;
      q_pop     = 1'b0;
      if (pri_valid) begin
         sec_valid  = 1'b1;
         sec_tag    = pri_tag;
         sec_status = pri_status;
      end else begin
         sec_valid  = !q_empty;
         sec_tag    = q_head;
         sec_status = CPL_UR;
         q_pop      = !q_empty && sec_ready;
      end
   end
endmodule

// File: rtl/usreq_gate.sv
module usreq_gate
   import usreq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int BEW       = 4,
   parameter int TW        = 8,
   parameter int LW        = 10,
   parameter int UR_DEPTH  = 4,
   parameter bit SERR_ONCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CMD_W-1:0] cfg_wdata,
   output logic [CMD_W-1:0] cfg_rdata,
   input  logic             devctl_err_en,
   output logic             serr_msg_en,
   input  logic             par_err_evt,
   input  logic             sts_clr,
   output logic             mdpe_sts,
   input  logic             dn_mem_hit,
   input  logic             dn_io_hit,
   output logic             dn_mem_claim,
   output logic             dn_io_claim,
   input  logic             up_in_valid,
   output logic             up_in_ready,
   input  logic [2:0]       up_in_kind,
   input  logic [AW-1:0]    up_in_addr,
   input  logic [BEW-1:0]   up_in_be,
   input  logic [TW-1:0]    up_in_tag,
   input  logic [LW-1:0]    up_in_len,
   output logic             up_out_valid,
   input  logic             up_out_ready,
   output logic [2:0]       up_out_kind,
   output logic [AW-1:0]    up_out_addr,
   output logic [BEW-1:0]   up_out_be,
   output logic [TW-1:0]    up_out_tag,
   output logic [LW-1:0]    up_out_len,
   output logic             up_out_inv,
   input  logic             pri_cpl_valid,
   output logic             pri_cpl_ready,
   input  logic [TW-1:0]    pri_cpl_tag,
   input  logic [1:0]       pri_cpl_status,
   output logic             sec_cpl_valid,
   input  logic             sec_cpl_ready,
   output logic [TW-1:0]    sec_cpl_tag,
   output logic [1:0]       sec_cpl_status
);
   generate
      if (AW < 2)       begin : g_bad_aw  $error("AW too small");       end
      if (BEW < 1)      begin : g_bad_bew $error("BEW must be >= 1");   end
      if (TW < 1)       begin : g_bad_tw  $error("TW must be >= 1");    end
      if (LW < 1)       begin : g_bad_lw  $error("LW must be >= 1");    end
      if (UR_DEPTH < 1) begin : g_bad_q   $error("UR_DEPTH must be >= 1"); end
   endgenerate

   logic [CMD_W-1:0] cmd;
   logic             q_full, q_empty, q_push, q_pop;
   logic [TW-1:0]    q_push_tag, q_head;

   usreq_cmd_reg #(.SERR_ONCE(SERR_ONCE)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .par_err_evt(par_err_evt), .sts_clr(sts_clr),
      .devctl_err_en(devctl_err_en), .cmd(cmd), .mdpe_sts(mdpe_sts),
      .serr_msg_en(serr_msg_en)
   );

   usreq_stage #(.AW(AW), .BEW(BEW), .TW(TW), .LW(LW)) u_stage (
      .clk(clk), .rst_n(rst_n), .bme(cmd[CB_BME]), .q_full(q_full),
      .in_valid(up_in_valid), .in_ready(up_in_ready), .in_kind(up_in_kind),
      .in_addr(up_in_addr), .in_be(up_in_be), .in_tag(up_in_tag),
      .in_len(up_in_len), .out_valid(up_out_valid), .out_ready(up_out_ready),
      .out_kind(up_out_kind), .out_addr(up_out_addr), .out_be(up_out_be),
      .out_tag(up_out_tag), .out_len(up_out_len), .out_inv(up_out_inv),
      .push(q_push), .push_tag(q_push_tag)
   );

   usreq_urq #(.TW(TW), .DEPTH(UR_DEPTH)) u_urq (
      .clk(clk), .rst_n(rst_n), .push(q_push), .push_tag(q_push_tag),
      .pop(q_pop), .empty(q_empty), .full(q_full), .head_tag(q_head)
   );

   usreq_cpl_mux #(.TW(TW)) u_mux (
      .pri_valid(pri_cpl_valid), .pri_ready(pri_cpl_ready),
      .pri_tag(pri_cpl_tag), .pri_status(pri_cpl_status),
      .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
      .sec_valid(sec_cpl_valid), .sec_ready(sec_cpl_ready),
      .sec_tag(sec_cpl_tag), .sec_status(sec_cpl_status)
   );

   assign cfg_rdata    = cmd;
   assign dn_mem_claim = dn_mem_hit & cmd[CB_MEM];
   assign dn_io_claim  = dn_io_hit & cmd[CB_IO];
endmodule

// File: rtl/usreq_gate_chk.sv
module usreq_gate_chk
   import usreq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int BEW       = 4,
   parameter int TW        = 8,
   parameter int LW        = 10,
   parameter int UR_DEPTH  = 4,
   parameter bit SERR_ONCE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [CMD_W-1:0] cfg_rdata,
   input logic             devctl_err_en,
   input logic             serr_msg_en,
   input logic             mdpe_sts,
   input logic             dn_mem_claim,
   input logic             dn_io_claim,
   input logic             up_out_valid,
   input logic             up_out_ready,
   input logic [2:0]       up_out_kind,
   input logic [AW-1:0]    up_out_addr,
   input logic [BEW-1:0]   up_out_be,
   input logic [TW-1:0]    up_out_tag,
   input logic             up_out_inv,
   input logic             pri_cpl_valid,
   input logic [TW-1:0]    pri_cpl_tag,
   input logic [1:0]       pri_cpl_status,
   input logic             sec_cpl_valid,
   input logic [TW-1:0]    sec_cpl_tag,
   input logic [1:0]       sec_cpl_status
);
   localparam logic [CMD_W-1:0] ZERO_BITS = 16'hFEB8;

   logic saw_wr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      saw_wr_q <= 1'b0;
      else if (cfg_wr) saw_wr_q <= 1'b1;
   end

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ZERO_BITS) == '0);

   generate
      if (SERR_ONCE) begin : g_once
         p_serr_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
            saw_wr_q |=> $stable(cfg_rdata[CB_SERR]));
      end
   endgenerate

   p_inv_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_out_valid && up_out_inv) |-> (up_out_addr == '0));

   p_inv_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_out_valid && up_out_inv && !kind_is_read(up_out_kind)) |-> (up_out_be == '0));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (up_out_valid && !up_out_ready) |=>
         (up_out_valid && $stable(up_out_addr) && $stable(up_out_tag) && $stable(up_out_inv)));

   p_pri_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pri_cpl_valid |-> (sec_cpl_valid && sec_cpl_tag == pri_cpl_tag
                         && sec_cpl_status == pri_cpl_status));

   p_mem_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dn_mem_claim |-> cfg_rdata[CB_MEM]);

   p_io_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dn_io_claim |-> cfg_rdata[CB_IO]);

   p_mdpe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rdata[CB_PERR] && !mdpe_sts) |=> !mdpe_sts);

   p_serr_or_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (devctl_err_en || cfg_rdata[CB_SERR]) |-> serr_msg_en);
endmodule

bind usreq_gate usreq_gate_chk #(
   .AW(AW), .BEW(BEW), .TW(TW), .LW(LW), .UR_DEPTH(UR_DEPTH), .SERR_ONCE(SERR_ONCE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
   .devctl_err_en(devctl_err_en), .serr_msg_en(serr_msg_en), .mdpe_sts(mdpe_sts),
   .dn_mem_claim(dn_mem_claim), .dn_io_claim(dn_io_claim),
   .up_out_valid(up_out_valid), .up_out_ready(up_out_ready),
   .up_out_kind(up_out_kind), .up_out_addr(up_out_addr), .up_out_be(up_out_be),
   .up_out_tag(up_out_tag), .up_out_inv(up_out_inv),
   .pri_cpl_valid(pri_cpl_valid), .pri_cpl_tag(pri_cpl_tag),
   .pri_cpl_status(pri_cpl_status), .sec_cpl_valid(sec_cpl_valid),
   .sec_cpl_tag(sec_cpl_tag), .sec_cpl_status(sec_cpl_status)
);

// File: tb/sim_usreq_gate.sv
module sim_usreq_gate;
   localparam int AW = 32, BEW = 4, TW = 8, LW = 10, QD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic cfg_wr = 0; logic [15:0] cfg_wdata = 0; logic [15:0] cfg_rdata;
   logic devctl_err_en = 0, serr_msg_en, par_err_evt = 0, sts_clr = 0, mdpe_sts;
   logic dn_mem_hit = 0, dn_io_hit = 0, dn_mem_claim, dn_io_claim;
   logic up_in_valid = 0, up_in_ready; logic [2:0] up_in_kind = 0;
   logic [AW-1:0] up_in_addr = 0; logic [BEW-1:0] up_in_be = 0;
   logic [TW-1:0] up_in_tag = 0; logic [LW-1:0] up_in_len = 0;
   logic up_out_valid, up_out_ready = 0, up_out_inv; logic [2:0] up_out_kind;
   logic [AW-1:0] up_out_addr; logic [BEW-1:0] up_out_be;
   logic [TW-1:0] up_out_tag; logic [LW-1:0] up_out_len;
   logic pri_cpl_valid = 0, pri_cpl_ready; logic [TW-1:0] pri_cpl_tag = 0;
   logic [1:0] pri_cpl_status = 0;
   logic sec_cpl_valid, sec_cpl_ready = 0; logic [TW-1:0] sec_cpl_tag;
   logic [1:0] sec_cpl_status;

   usreq_gate #(.AW(AW), .BEW(BEW), .TW(TW), .LW(LW), .UR_DEPTH(QD)) u0 (.*);

   int n_cmp = 0, n_bad = 0;

   // reference model state
   logic [15:0] m_cmd; logic m_lock, m_mdpe, m_ov, m_inv, m_acc;
   logic [2:0] m_kind; logic [AW-1:0] m_addr; logic [BEW-1:0] m_be;
   logic [TW-1:0] m_tag; logic [LW-1:0] m_len;
   int m_q[$];

   function automatic bit is_rd(input logic [2:0] k);
      return (k == 3'd0) || (k == 3'd2);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = 0; m_lock = 0; m_mdpe = 0; m_ov = 0; m_inv = 0; m_acc = 0;
         m_kind = 0; m_addr = 0; m_be = 0; m_tag = 0; m_len = 0;
         m_q.delete();
      end else begin
         bit rdy, acc, pop, bme;
         rdy = (!m_ov || up_out_ready) && (m_q.size() < QD);
         acc = up_in_valid && rdy;
         pop = !pri_cpl_valid && (m_q.size() > 0) && sec_cpl_ready;
         bme = m_cmd[2];
         if (pop) void'(m_q.pop_front());
         if (acc && !bme && is_rd(up_in_kind)) m_q.push_back(int'(up_in_tag));
         if (acc) begin
            m_kind = up_in_kind; m_tag = up_in_tag; m_len = up_in_len;
            m_addr = bme ? up_in_addr : '0;
            m_be = (!bme && !is_rd(up_in_kind)) ? '0 : up_in_be;
            m_inv = !bme; m_ov = 1;
         end else if (up_out_ready) m_ov = 0;
         if (par_err_evt && m_cmd[6]) m_mdpe = 1;
         else if (sts_clr) m_mdpe = 0;
         if (cfg_wr) begin
            logic s8;
            s8 = m_lock ? m_cmd[8] : cfg_wdata[8];
            m_cmd = cfg_wdata & 16'h0047;
            m_cmd[8] = s8; m_lock = 1;
         end
         m_acc = acc;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit e_rdy, e_sv; logic [TW-1:0] e_st; logic [1:0] e_ss; string t;
      chk(cfg_rdata === m_cmd, "R2 command value", cfg_rdata, m_cmd);
      chk(up_out_valid === m_ov, "R8 out valid", up_out_valid, m_ov);
      e_rdy = (!m_ov || up_out_ready) && (m_q.size() < QD);
      chk(up_in_ready === e_rdy, "R8 in ready", up_in_ready, e_rdy);
      if (m_ov) begin
         t = !m_inv ? "R4" : (is_rd(m_kind) ? "R6" : "R5");
         chk(up_out_addr === m_addr, {t, " addr"}, up_out_addr, m_addr);
         chk(up_out_be === m_be, {t, " be"}, up_out_be, m_be);
         chk(up_out_tag === m_tag && up_out_len === m_len && up_out_kind === m_kind,
             {t, " tag/len/kind"}, {up_out_kind, up_out_len, up_out_tag},
             {m_kind, m_len, m_tag});
         chk(up_out_inv === m_inv, {t, " inv flag"}, up_out_inv, m_inv);
      end
      e_sv = pri_cpl_valid || (m_q.size() > 0);
      chk(sec_cpl_valid === e_sv, "R9 sec valid", sec_cpl_valid, e_sv);
      if (e_sv) begin
         e_st = pri_cpl_valid ? pri_cpl_tag : TW'(m_q[0]);
         e_ss = pri_cpl_valid ? pri_cpl_status : 2'd1;
         chk(sec_cpl_tag === e_st && sec_cpl_status === e_ss,
             pri_cpl_valid ? "R9 sec cpl" : "R6 UR cpl",
             {sec_cpl_status, sec_cpl_tag}, {e_ss, e_st});
      end
      chk(pri_cpl_ready === sec_cpl_ready, "R9 pri ready", pri_cpl_ready, sec_cpl_ready);
      chk(dn_mem_claim === (dn_mem_hit & m_cmd[1]) && dn_io_claim === (dn_io_hit & m_cmd[0]),
          "R10 claims", {dn_mem_claim, dn_io_claim},
          {dn_mem_hit & m_cmd[1], dn_io_hit & m_cmd[0]});
      chk(mdpe_sts === m_mdpe, "R11 parity status", mdpe_sts, m_mdpe);
      chk(serr_msg_en === (m_cmd[8] | devctl_err_en), "R12 error enable",
          serr_msg_en, m_cmd[8] | devctl_err_en);
   endtask

   task automatic idle_in();
      cfg_wr = 0; par_err_evt = 0; sts_clr = 0; up_in_valid = 0; pri_cpl_valid = 0;
   endtask

   task automatic put_req(input logic [2:0] k, input logic [AW-1:0] a,
                          input logic [BEW-1:0] b, input logic [TW-1:0] tg);
      up_in_valid = 1; up_in_kind = k; up_in_addr = a; up_in_be = b;
      up_in_tag = tg; up_in_len = LW'(tg) + LW'(3);
   endtask

   task automatic rnd_cycle(input int p_cfg, input int p_rd, input int p_pri,
                            input int p_sready, input int p_oready);
      cfg_wr = ($urandom_range(99) < p_cfg);
      cfg_wdata = 16'($urandom);
      devctl_err_en = ($urandom_range(9) == 0);
      par_err_evt = ($urandom_range(7) == 0);
      sts_clr = ($urandom_range(7) == 0);
      dn_mem_hit = $urandom_range(1); dn_io_hit = $urandom_range(1);
      up_out_ready = ($urandom_range(99) < p_oready);
      sec_cpl_ready = ($urandom_range(99) < p_sready);
      if (!pri_cpl_valid || sec_cpl_ready) begin
         pri_cpl_valid = ($urandom_range(99) < p_pri);
         pri_cpl_tag = TW'($urandom); pri_cpl_status = 2'($urandom_range(2) * 2);
      end
      if (!up_in_valid || m_acc) begin
         logic [2:0] k;
         k = ($urandom_range(99) < p_rd) ? 3'(2 * $urandom_range(1))
                                         : 3'(1 + 2 * $urandom_range(1) + $urandom_range(1));
         if ($urandom_range(4) == 0) k = 3'($urandom_range(5, 7));
         up_in_valid = $urandom_range(3) != 0;
         up_in_kind = k; up_in_addr = AW'($urandom) | AW'(1);
         up_in_be = BEW'($urandom) | BEW'(1); up_in_tag = TW'($urandom);
         up_in_len = LW'($urandom);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_rdata === 16'h0, "R1 cmd after reset", cfg_rdata, 0);
      chk(up_out_valid === 1'b0, "R1 no upstream output", up_out_valid, 0);
      chk(sec_cpl_valid === 1'b0, "R1 no completion", sec_cpl_valid, 0);
      chk(mdpe_sts === 1'b0, "R1 parity status", mdpe_sts, 0);
      compare_all();

      // R3 write-once bit 8: first write sets it, later write of 0 is ignored
      cfg_wr = 1; cfg_wdata = 16'hFFFF; up_out_ready = 1; sec_cpl_ready = 1;
      @(negedge clk); compare_all();
      chk(cfg_rdata === 16'h0147, "R2 writable mask", cfg_rdata, 16'h0147);
      cfg_wdata = 16'h0000;
      @(negedge clk); compare_all();
      chk(cfg_rdata[8] === 1'b1, "R3 bit 8 locked", cfg_rdata[8], 1);

      // R5 invalidated message write with bus mastering off
      cfg_wr = 0; put_req(3'd4, 32'h1234, 4'hF, 8'h21);
      @(negedge clk); compare_all();
      chk(up_out_addr === 0 && up_out_be === 0 && up_out_tag === 8'h21,
          "R5 MSI neutralized", {up_out_addr, up_out_be}, 0);

      // R7 request in the same cycle as the write that enables bus mastering
      cfg_wr = 1; cfg_wdata = 16'h0004; put_req(3'd0, 32'hABC0, 4'h3, 8'h55);
      @(negedge clk); compare_all();
      chk(up_out_inv === 1'b1, "R7 old enable used", up_out_inv, 1);
      chk(sec_cpl_valid && sec_cpl_tag === 8'h55 && sec_cpl_status === 2'd1,
          "R6 UR completion", {sec_cpl_status, sec_cpl_tag}, {2'd1, 8'h55});
      cfg_wr = 0; put_req(3'd0, 32'hABC4, 4'h3, 8'h66);
      @(negedge clk); compare_all();
      chk(up_out_inv === 1'b0 && up_out_addr === 32'hABC4, "R7 new enable used",
          up_out_addr, 32'hABC4);
      idle_in();
      @(negedge clk); compare_all();

      // random phases: mild traffic, then read-heavy congestion with stalls
      for (int i = 0; i < 1500; i++) begin
         rnd_cycle(5, 50, 20, 70, 70);
         @(negedge clk); compare_all();
      end
      cfg_wr = 1; cfg_wdata = 16'h0043;
      @(negedge clk); compare_all();
      for (int i = 0; i < 1500; i++) begin
         rnd_cycle(0, 90, 60, 15, 80);
         if (cfg_wr) cfg_wr = 0;
         @(negedge clk); compare_all();
      end
      for (int i = 0; i < 1000; i++) begin
         rnd_cycle(8, 60, 30, 50, 40);
         @(negedge clk); compare_all();
      end
      idle_in(); up_out_ready = 1; sec_cpl_ready = 1;
      repeat (10) begin @(negedge clk); compare_all(); end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule